// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

A register-mapped controller for one bank of 32 general-purpose pins. Software reaches it through a plain 32-bit register bus with one access per cycle. Each pin is either driven from an output latch or left as an input. The output latch and the two edge-enable masks change only through paired set and clear registers, so one write can change some bits of a mask without a read-modify-write.

Every pin level passes through a two-flop synchronizer. The synchronized level can always be read back, including on pins that the block drives itself. A rising edge and a falling edge can each be enabled per pin. An enabled edge latches a bit in a sticky status register, and software clears that bit by writing a 1 to it. The bank drives two interrupt lines, one for pins 15:0 and one for pins 31:16, and each line is gated by its own bit in a bank-enable register.

The register bus is a control path and has no back-pressure. A request is taken in the cycle in which `bus_sel` is high. Read data comes back one cycle later, marked by `bus_rvalid`.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every register reads zero, `pin_oe` is all ones (every pin driven), `pin_out` is zero and both `irq` lines are low.
- R2: Direction register at byte offset 0x10: bit value 1 makes the pin an input (`pin_oe` bit 0), bit value 0 drives it (`pin_oe` bit 1). The register reads back as written.
- R3: Writing to offset 0x18 sets the output-latch bits given as 1, and writing to offset 0x1C clears them. Bits written as 0 are left unchanged. The latch drives `pin_out` and reads back at 0x14, 0x18 and 0x1C.
- R4: A write to the output-data offset 0x14 is ignored. The latch keeps its value.
- R5: Offset 0x20 returns the synchronized level of every pin, whatever its direction. A read issued in the cycle after a pin changes still returns the old level, and the new level is returned from the third cycle onward.
- R6: Writing 1s to 0x24 or 0x28 sets or clears rising-edge enables. Writing 1s to 0x2C or 0x30 sets or clears falling-edge enables. The rising mask reads back at 0x24 and 0x28, and the falling mask at 0x2C and 0x30.
- R7: An enabled rising or falling transition of a synchronized pin sets that pin's bit in the status register at 0x34. With both enables on, either edge sets the bit. A transition whose edge is not enabled sets nothing.
- R8: Writing 1s to 0x34 clears those status bits. Bits written as 0 stay as they are.
- R9: If a new enabled edge on a pin arrives in the same cycle as a clear of that pin's status bit, the bit stays set.
- R10: `irq[0]` is high exactly when some status bit in 15:0 is set and bit 0 of the bank-enable register at 0x08 is set. `irq[1]` does the same for bits 31:16 and enable bit 1.
- R11: `bus_rvalid` rises in the cycle after each read request and carries the read data in that cycle. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bank |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| pin_in | input | 32 | Raw pin levels, asynchronous |
| pin_out | output | 32 | Output latch value |
| pin_oe | output | 32 | Per-pin drive enable, 1 = driven |
| irq | output | 2 | Interrupt lines for pins 15:0 and 31:16 |

## Verification
The assertions assume that the pins are held low through reset. A pin that is high as reset ends is seen as a rising edge, and that edge is correct behaviour. They also assume that a bus request carries a defined address and write flag. The stimulus changes pins and bus signals only on the falling clock edge and keeps pins at zero during reset. It spaces the pin changes far enough apart that each change has passed through the synchronizer before the next one, except where a test deliberately lines up an edge with a status clear.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 8;

  // byte offsets; the bank block starts at 0x10, enable word sits below it
  localparam logic [ADDR_W-1:0] OFS_BANK_EN  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_DIR      = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_OUT      = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_OUT_SET  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_OUT_CLR  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_IN       = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_RISE_SET = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_RISE_CLR = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_FALL_SET = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_FALL_CLR = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_STATUS   = 8'h34;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_edge_latch.sv
module gpio_edge_latch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] status
);
  logic [W-1:0] prev_q;
  logic [W-1:0] hit;
  logic [W-1:0] status_q;

  assign hit = (level & ~prev_q & rise_en) | (~level & prev_q & fall_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= level;
      // a fresh edge overrides a clear aimed at the same bit
      status_q <= (status_q & ~clr_mask) | hit;
    end
  end

  assign status = status_q;

  // R9: an edge seen this cycle is present in status next cycle
  a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(hit)) == $past(hit)));

  // R8: without a clear, no status bit drops
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask == '0) |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R7: newly set bits belong only to pins with some edge enabled
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~($past(rise_en) | $past(fall_en))) == '0));
endmodule

// File: rtl/gpio_irq_groups.sv
module gpio_irq_groups #(
  parameter int W   = 32,
  parameter int GRP = 16,
  localparam int NG = W / GRP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  status,
  input  logic [NG-1:0] grp_en,
  output logic [NG-1:0] irq
);
  for (genvar g = 0; g < NG; g++) begin : g_line
    assign irq[g] = grp_en[g] & (|status[g*GRP +: GRP]);

    // R10: a line stays low while its enable is off
    a_r10_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !grp_en[g] |-> !irq[g]);
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int W  = 32,
  parameter int NG = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      in_sync,
  input  logic [W-1:0]      status,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      out_q,
  output logic [W-1:0]      rise_q,
  output logic [W-1:0]      fall_q,
  output logic [NG-1:0]     grp_en_q,
  output logic [W-1:0]      stat_clr,
  output logic [W-1:0]      rdata,
  output logic              rvalid
);
  logic [W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q    <= '0;
      out_q    <= '0;
      rise_q   <= '0;
      fall_q   <= '0;
      grp_en_q <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_BANK_EN:  grp_en_q <= wdata[NG-1:0];
        OFS_DIR:      dir_q    <= wdata;
        OFS_OUT_SET:  out_q    <= out_q | wdata;
        OFS_OUT_CLR:  out_q    <= out_q & ~wdata;
        OFS_RISE_SET: rise_q   <= rise_q | wdata;
        OFS_RISE_CLR: rise_q   <= rise_q & ~wdata;
        OFS_FALL_SET: fall_q   <= fall_q | wdata;
        OFS_FALL_CLR: fall_q   <= fall_q & ~wdata;
        default: ;
      endcase
    end
  end

  assign stat_clr = (wr_en && addr == OFS_STATUS) ? wdata : '0;

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_BANK_EN:                rd_mux[NG-1:0] = grp_en_q;
      OFS_DIR:                    rd_mux = dir_q;
      OFS_OUT, OFS_OUT_SET,
      OFS_OUT_CLR:                rd_mux = out_q;
      OFS_IN:                     rd_mux = in_sync;
      OFS_RISE_SET, OFS_RISE_CLR: rd_mux = rise_q;
      OFS_FALL_SET, OFS_FALL_CLR: rd_mux = fall_q;
      OFS_STATUS:                 rd_mux = status;
      default:                    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

  // R4: writes to the output-data word never move the latch
  a_r4_out_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_OUT) |=> $stable(out_q));

  // R3: a set write leaves every written-1 bit high
  a_r3_set_adds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_OUT_SET) |=> ((out_q & $past(wdata)) == $past(wdata)));

  // R6: a clear write leaves every written-1 rising-enable bit low
  a_r6_rise_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_RISE_CLR) |=> ((rise_q & $past(wdata)) == '0));
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int PINS = 32,
  parameter int GRP  = 16,
  localparam int NG  = PINS / GRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  output logic              bus_rvalid,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [NG-1:0]     irq
);
  logic [PINS-1:0] in_sync;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] out_q;
  logic [PINS-1:0] rise_q;
  logic [PINS-1:0] fall_q;
  logic [PINS-1:0] stat_clr;
  logic [PINS-1:0] status;
  logic [NG-1:0]   grp_en;
  logic            wr_en;
  logic            rd_en;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;

  gpio_sync2 #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(in_sync)
  );

  gpio_bank_regs #(.W(PINS), .NG(NG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(bus_addr), .wdata(bus_wdata), .in_sync(in_sync), .status(status),
    .dir_q(dir_q), .out_q(out_q), .rise_q(rise_q), .fall_q(fall_q),
    .grp_en_q(grp_en), .stat_clr(stat_clr), .rdata(bus_rdata),
    .rvalid(bus_rvalid)
  );

  gpio_edge_latch #(.W(PINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(in_sync), .rise_en(rise_q),
    .fall_en(fall_q), .clr_mask(stat_clr), .status(status)
  );

  gpio_irq_groups #(.W(PINS), .GRP(GRP)) u_irq (
    .clk(clk), .rst_n(rst_n), .status(status), .grp_en(grp_en), .irq(irq)
  );

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;

  // R11: each read request is answered on the following cycle
  a_r11_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid);

  // R11: no read data valid without a request one cycle earlier
  a_r11_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> !bus_rvalid);
endmodule

// File: tb/tb_gpio_edge_bank.sv
`timescale 1ns/1ps
module tb_gpio_edge_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic [1:0]  irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  gpio_edge_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  // {write, addr, data, expected read, requirement number}
  localparam int NV = 16;
  localparam logic [76:0] VEC [0:NV-1] = '{
    {1'b1, 8'h10, 32'h0000FFFF, 32'h0,        4'd2},  // R2 low half inputs
    {1'b0, 8'h10, 32'h0,        32'h0000FFFF, 4'd2},  // R2
    {1'b1, 8'h18, 32'hA5A50F0F, 32'h0,        4'd3},  // R3 set
    {1'b0, 8'h14, 32'h0,        32'hA5A50F0F, 4'd3},  // R3
    {1'b1, 8'h1C, 32'h0000000F, 32'h0,        4'd3},  // R3 clear
    {1'b0, 8'h18, 32'h0,        32'hA5A50F00, 4'd3},  // R3
    {1'b1, 8'h14, 32'hFFFFFFFF, 32'h0,        4'd4},  // R4 ignored write
    {1'b0, 8'h14, 32'h0,        32'hA5A50F00, 4'd4},  // R4
    {1'b1, 8'h24, 32'h00000003, 32'h0,        4'd6},  // R6
    {1'b1, 8'h2C, 32'h00010002, 32'h0,        4'd6},  // R6
    {1'b1, 8'h28, 32'h00000001, 32'h0,        4'd6},  // R6
    {1'b0, 8'h24, 32'h0,        32'h00000002, 4'd6},  // R6
    {1'b0, 8'h28, 32'h0,        32'h00000002, 4'd6},  // R6
    {1'b0, 8'h30, 32'h0,        32'h00010002, 4'd6},  // R6
    {1'b0, 8'h40, 32'h0,        32'h0,        4'd11}, // R11 unmapped
    {1'b0, 8'h34, 32'h0,        32'h0,        4'd7}   // R7 nothing yet
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    n_tests++;
    if (bus_rvalid !== 1'b1) begin
      n_fail++;
      $display("FAIL R11: rvalid actual %b expected 1", bus_rvalid);
    end
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] pins;
    pins = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pin_oe", pin_oe, 32'hFFFFFFFF);
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 irq", {30'h0, irq}, 32'h0);
    rd(8'h10, d); chk("R1 dir", d, 32'h0);
    rd(8'h08, d); chk("R1 bank enable", d, 32'h0);

    // register vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr(VEC[i][75:68], VEC[i][67:36]);
      else begin
        rd(VEC[i][75:68], d);
        n_tests++;
        if (d !== VEC[i][35:4]) begin
          n_fail++;
          $display("FAIL R%0d: vector %0d actual %h expected %h",
                   VEC[i][3:0], i, d, VEC[i][35:4]);
        end
      end
    end
    chk("R2 pin_oe", pin_oe, 32'hFFFF0000);
    chk("R3 pin_out", pin_out, 32'hA5A50F00);

    // R7 edge on a pin with no enable
    pins = 32'h1; pin_in = pins; settle();
    rd(8'h34, d); chk("R7 disabled edge", d, 32'h0);

    // R7 rising edge on bit1; R10 line held off by enable
    pins = 32'h3; pin_in = pins; settle();
    rd(8'h34, d); chk("R7 rise", d, 32'h2);
    chk("R10 irq gated", {30'h0, irq}, 32'h0);
    wr(8'h08, 32'h1);
    chk("R10 irq0 on", {30'h0, irq}, 32'h1);

    // R8 zeros leave bits, ones clear
    wr(8'h34, 32'h1);
    rd(8'h34, d); chk("R8 zero kept", d, 32'h2);
    wr(8'h34, 32'h2);
    rd(8'h34, d); chk("R8 cleared", d, 32'h0);
    chk("R10 irq0 off", {30'h0, irq}, 32'h0);

    // R7 falling edge on a both-edge pin
    pins = 32'h1; pin_in = pins; settle();
    rd(8'h34, d); chk("R7 fall", d, 32'h2);

    // R9 clear lands in the same cycle as a new rising edge
    pins = 32'h3; pin_in = pins;
    @(negedge clk);
    wr(8'h34, 32'h2);
    rd(8'h34, d); chk("R9 edge wins", d, 32'h2);
    wr(8'h34, 32'h2);
    rd(8'h34, d); chk("R9 then cleared", d, 32'h0);

    // R7/R10 upper half: rise not enabled, fall enabled
    pins = 32'h10003; pin_in = pins; settle();
    rd(8'h34, d); chk("R7 rise not enabled", d, 32'h0);
    pins = 32'h3; pin_in = pins; settle();
    rd(8'h34, d); chk("R7 fall bit16", d, 32'h10000);
    chk("R10 irq1 gated", {30'h0, irq}, 32'h0);
    wr(8'h08, 32'h3);
    chk("R10 irq1 on", {30'h0, irq}, 32'h2);
    wr(8'h34, 32'h10000);

    // R5 input readback on a driven pin, with synchronizer latency
    pins = 32'h80000003; pin_in = pins;
    rd(8'h20, d); chk("R5 old level", d, 32'h3);
    repeat (3) @(negedge clk);
    rd(8'h20, d); chk("R5 new level", d, 32'h80000003);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule